// File: doc/BRIEF.md
# Idle-Gated Hub Port Enable Controller

This block decides which of the switchable ports of a bus hub take part in traffic. Each switchable port has an active-high enable request. The request is the OR of a central control line and a local control line, so either side can turn the channel on. Port 0 has no gate and stays outside this block.

A requested change is never applied at once. The block watches the shared SCL/SDA pair for START and STOP conditions. It applies a change only after the bus has been idle for a full setup/hold window, and only while that port's own segment is idle. A port therefore never joins or leaves in the middle of a transaction.

A disabled port presents a released (high) line to the hub logic in place of its inputs, and its pull-down drivers stay off. An enabled port passes its SDA/SCL inputs to the hub, and its pull-downs follow the hub's drive requests.

Top module: `hub_port_gate`

## Requirements
- R1: After reset all four enables are on (bit i of `port_en` = port i+1), and the bus counts as idle, with the idle window starting from zero.
- R2: An SDA fall while SCL is high (START) marks the bus busy. No enable changes while the bus is busy.
- R3: An SDA rise while SCL is high (STOP) marks the bus idle. A pending change takes effect on the (WIN+3)th clock edge after the STOP is first sampled. WIN is ceil(300 ns x clock rate), which is 15 at 50 MHz; the window covers the 2-stage synchronizer, WIN idle cycles and the enable register.
- R4: While a port's own SDA or SCL input is low, that port's enable holds its value. Other ports still take their pending changes.
- R5: The request for port i is `ctl_req[i] | loc_req[i]`. Either input high asks for on, and both low asks for off.
- R6: Bit i of `hub_sda_o`/`hub_scl_o` is 1 while port i is disabled, and equals `port_sda_i[i]`/`port_scl_i[i]` while it is enabled.
- R7: Bit i of `port_sda_pd`/`port_scl_pd` is high only when port i is enabled and `hub_sda_drv`/`hub_scl_drv` is high.
- R8: A START that arrives before the idle window is complete keeps the pending change waiting until the next STOP plus a full window.
- R9: An SDA change while SCL is low is neither START nor STOP. It leaves the busy/idle state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_scl | input | 1 | shared bus clock line level |
| bus_sda | input | 1 | shared bus data line level |
| ctl_req | input | NPORTS | central enable requests |
| loc_req | input | NPORTS | local enable requests |
| port_scl_i | input | NPORTS | per-port SCL input level |
| port_sda_i | input | NPORTS | per-port SDA input level |
| hub_scl_drv | input | 1 | hub asks ports to pull SCL low |
| hub_sda_drv | input | 1 | hub asks ports to pull SDA low |
| port_en | output | NPORTS | applied enables |
| hub_scl_o | output | NPORTS | gated SCL toward hub logic |
| hub_sda_o | output | NPORTS | gated SDA toward hub logic |
| port_scl_pd | output | NPORTS | SCL pull-down enables |
| port_sda_pd | output | NPORTS | SDA pull-down enables |

## Verification
Enable changes during a long idle period appear on the third clock edge after the request is sampled. After a STOP they appear on edge WIN+3. The gating and pull-down outputs are combinational and follow their inputs in the same cycle. The bench drives inputs on the falling edge and samples 5 ns after each rising edge. A behavioural model with the same sample latencies is compared against every output on every cycle. The STOP-to-enable latency is measured by counting edges until `port_en` changes and comparing the count against WIN+3.

// File: rtl/hub_port_gate.sv
module hub_port_gate #(
  parameter int NPORTS  = 4,
  parameter int CLK_MHZ = 50,
  parameter int WIN_NS  = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_scl,
  input  logic              bus_sda,
  input  logic [NPORTS-1:0] ctl_req,
  input  logic [NPORTS-1:0] loc_req,
  input  logic [NPORTS-1:0] port_scl_i,
  input  logic [NPORTS-1:0] port_sda_i,
  input  logic              hub_scl_drv,
  input  logic              hub_sda_drv,
  output logic [NPORTS-1:0] port_en,
  output logic [NPORTS-1:0] hub_scl_o,
  output logic [NPORTS-1:0] hub_sda_o,
  output logic [NPORTS-1:0] port_scl_pd,
  output logic [NPORTS-1:0] port_sda_pd
);
  localparam int WIN = (WIN_NS * CLK_MHZ + 999) / 1000;
  localparam int CW  = $clog2(WIN + 1);

  logic [2:0]        scl_sh, sda_sh;
  logic [NPORTS-1:0] req_s1, req_s2, lid_s1, loc_idle;
  logic              busy_q, busy_nxt, start_det, stop_det, open_win;
  logic [CW-1:0]     idle_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[1:0], bus_scl};
      sda_sh <= {sda_sh[1:0], bus_sda};
    end

  assign start_det = scl_sh[1] & scl_sh[2] &  sda_sh[2] & ~sda_sh[1];
  assign stop_det  = scl_sh[1] & scl_sh[2] & ~sda_sh[2] &  sda_sh[1];
  assign busy_nxt  = start_det | (busy_q & ~stop_det);
  assign open_win  = (idle_cnt == CW'(WIN)) & ~busy_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q   <= 1'b0;
      idle_cnt <= '0;
    end else begin
      busy_q <= busy_nxt;
      if (busy_nxt)
        idle_cnt <= '0;
      else if (idle_cnt != CW'(WIN))
        idle_cnt <= idle_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_s1   <= '1;
      req_s2   <= '1;
      lid_s1   <= '1;
      loc_idle <= '1;
    end else begin
      req_s1   <= ctl_req | loc_req;
      req_s2   <= req_s1;
      lid_s1   <= port_scl_i & port_sda_i;
      loc_idle <= lid_s1;
    end

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        port_en[i] <= 1'b1;
      else if (open_win && loc_idle[i])
        port_en[i] <= req_s2[i];
  end

  assign hub_scl_o   = port_scl_i | ~port_en;
  assign hub_sda_o   = port_sda_i | ~port_en;
  assign port_scl_pd = port_en & {NPORTS{hub_scl_drv}};
  assign port_sda_pd = port_en & {NPORTS{hub_sda_drv}};
endmodule

// File: rtl/hub_port_gate_chk.sv
module hub_port_gate_chk #(
  parameter int NPORTS = 4,
  parameter int WIN    = 15,
  parameter int CW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_q,
  input logic              start_det,
  input logic              stop_det,
  input logic [CW-1:0]     idle_cnt,
  input logic [NPORTS-1:0] loc_idle,
  input logic [NPORTS-1:0] port_en
);
  assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy_q);

  assert_stop_clears_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> !busy_q);

  assert_hold_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> $stable(port_en));

  assert_change_after_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en != $past(port_en)) |-> ($past(idle_cnt) == CW'(WIN)));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= CW'(WIN));

  for (genvar i = 0; i < NPORTS; i++) begin : g_loc
    assert_local_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en[i] != $past(port_en[i])) |-> $past(loc_idle[i]));
  end
endmodule

bind hub_port_gate hub_port_gate_chk #(.NPORTS(NPORTS), .WIN(WIN), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_q(busy_q), .start_det(start_det),
  .stop_det(stop_det), .idle_cnt(idle_cnt), .loc_idle(loc_idle), .port_en(port_en)
);

// File: tb/sim_hub_port_gate.sv
`timescale 1ns/1ps
module sim_hub_port_gate;
  localparam int WIN = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_scl = 1'b1, bus_sda = 1'b1;
  logic [3:0] ctl_req = 4'hF, loc_req = 4'h0;
  logic [3:0] port_scl_i = 4'hF, port_sda_i = 4'hF;
  logic hub_scl_drv = 1'b0, hub_sda_drv = 1'b0;
  logic [3:0] port_en, hub_scl_o, hub_sda_o, port_scl_pd, port_sda_pd;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hub_port_gate u0 (
    .clk(clk), .rst_n(rst_n), .bus_scl(bus_scl), .bus_sda(bus_sda),
    .ctl_req(ctl_req), .loc_req(loc_req), .port_scl_i(port_scl_i), .port_sda_i(port_sda_i),
    .hub_scl_drv(hub_scl_drv), .hub_sda_drv(hub_sda_drv), .port_en(port_en),
    .hub_scl_o(hub_scl_o), .hub_sda_o(hub_sda_o), .port_scl_pd(port_scl_pd),
    .port_sda_pd(port_sda_pd)
  );

  // behavioural reference
  logic [1:0] bq[$];
  logic [3:0] rq[$], lq[$];
  logic [3:0] en_m = 4'hF;
  bit busy_m = 0;
  int idle_m = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      bq = '{2'b11, 2'b11, 2'b11, 2'b11};
      rq = '{4'hF, 4'hF};
      lq = '{4'hF, 4'hF};
      en_m = 4'hF; busy_m = 0; idle_m = 0;
    end else begin
      logic [1:0] nw, od;
      logic [3:0] rv, lv;
      bit st, sp, bn;
      bq.push_back({bus_scl, bus_sda});
      rq.push_back(ctl_req | loc_req);
      lq.push_back(port_scl_i & port_sda_i);
      nw = bq[bq.size()-3];
      od = bq[bq.size()-4];
      rv = rq[0];
      lv = lq[0];
      void'(bq.pop_front());
      void'(rq.pop_front());
      void'(lq.pop_front());
      st = nw[1] && od[1] && od[0] && !nw[0];
      sp = nw[1] && od[1] && !od[0] && nw[0];
      bn = st ? 1'b1 : (sp ? 1'b0 : busy_m);
      if (idle_m == WIN && !bn)
        for (int i = 0; i < 4; i++) if (lv[i]) en_m[i] = rv[i];
      if (bn) idle_m = 0;
      else if (idle_m < WIN) idle_m++;
      busy_m = bn;
    end
  end

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      check("R3 en", port_en, en_m);
      check("R6 sda", hub_sda_o, port_sda_i | ~en_m);
      check("R6 scl", hub_scl_o, port_scl_i | ~en_m);
      check("R7 sda_pd", port_sda_pd, en_m & {4{hub_sda_drv}});
      check("R7 scl_pd", port_scl_pd, en_m & {4{hub_scl_drv}});
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sample();
    @(posedge clk); #5;
  endtask

  task automatic stop_measure(string tag, logic [3:0] exp);
    int k = 0;
    @(negedge clk); bus_sda = 1'b1;
    while (k < 100) begin
      @(posedge clk); k++; #5;
      if (port_en == exp) break;
    end
    check({tag, " latency"}, 4'(k), 4'(WIN + 3));
    check({tag, " value"}, port_en, exp);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    sample(); check("R1 reset en", port_en, 4'hF);
    cyc(20);

    // R5: wired-OR request
    ctl_req = 4'b1110; cyc(5); sample(); check("R5 both low off", port_en, 4'b1110);
    @(negedge clk); loc_req = 4'b0001; cyc(5); sample(); check("R5 local on", port_en, 4'hF);

    // R6/R7: gating and pull-downs
    @(negedge clk); loc_req = 4'h0; ctl_req = 4'b1011; cyc(5);
    port_sda_i = 4'h0; hub_sda_drv = 1'b1;
    sample(); check("R6 gated sda", hub_sda_o, 4'b0100);
    check("R7 sda pulldown", port_sda_pd, 4'b1011);
    @(negedge clk); port_sda_i = 4'hF; hub_sda_drv = 1'b0; cyc(5);

    // R2/R9: busy defers changes, data toggles do not end busy
    bus_sda = 1'b0; cyc(3); bus_scl = 1'b0; cyc(2);
    ctl_req = 4'hF; cyc(5);
    bus_sda = 1'b1; cyc(5); bus_sda = 1'b0; cyc(20);
    sample(); check("R2 held while busy", port_en, 4'b1011);
    @(negedge clk); bus_scl = 1'b1; cyc(3);
    stop_measure("R3", 4'hF);

    // R8: START inside window postpones
    cyc(30);
    bus_sda = 1'b0; cyc(3); bus_scl = 1'b0; cyc(5); bus_scl = 1'b1; cyc(3);
    bus_sda = 1'b1; cyc(2); ctl_req = 4'b1110; cyc(5);
    bus_sda = 1'b0; cyc(30);
    sample(); check("R8 postponed", port_en, 4'hF);
    @(negedge clk); bus_scl = 1'b0; cyc(3); bus_scl = 1'b1; cyc(3);
    stop_measure("R8", 4'b1110);

    // R4: local segment busy holds its own port only
    cyc(5);
    port_sda_i[3] = 1'b0; cyc(5);
    ctl_req = 4'b0111; cyc(20);
    sample(); check("R4 local busy held", port_en, 4'hF);
    @(negedge clk); port_sda_i[3] = 1'b1; cyc(6);
    sample(); check("R4 released", port_en, 4'b0111);

    // R9: SDA fall with SCL low is not a START
    @(negedge clk); bus_scl = 1'b0; cyc(3);
    bus_sda = 1'b0; cyc(3); ctl_req = 4'hF; cyc(6);
    sample(); check("R9 no start", port_en, 4'hF);
    @(negedge clk); bus_sda = 1'b1; cyc(3); bus_scl = 1'b1; cyc(5);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule